// File: doc/BRIEF.md
# Sticky Event Status Register with Enable Mask

This block holds the eight event flags that a remotely controlled instrument keeps for its host, together with an eight-bit enable mask of the same shape. Other logic in the instrument raises a one-cycle pulse on the matching event line whenever it sees that condition:

- a malformed command;
- a command that cannot run in the present state;
- an internal fault;
- a query with nothing to answer;
- completion of a requested operation.

The register catches each pulse and keeps it until the host empties the register. The summary output goes to the status byte logic elsewhere. It is high while at least one caught event is also enabled.

The host empties the event register in one of two ways. The first is a destructive read, where the value on the read port is taken and the register is cleared at the same edge. The second is a separate clear command. The enable mask is written and read independently, and neither the read nor the clear touches it.

Leaving reset, the register shows only the power-on flag. Two positions carry no event in this instrument and always read zero.

Fixed bit positions, which the status logic depends on:

| Bit | Meaning |
|-----|---------|
| 7 | power-on |
| 6 | tied to zero |
| 5 | command error |
| 4 | execution error |
| 3 | device error |
| 2 | query error |
| 1 | tied to zero |
| 0 | operation complete |

Top module: `event_status_reg`

## Requirements
- R1: While and after reset the event port `evt_rd_data` reads 0x80 (only bit 7 set), the mask port `ena_rdata` reads 0x00, and `summary` is 0.
- R2: Bits 6 and 1 of `evt_rd_data` are always 0, even when `evt_pulse` carries a 1 on those positions.
- R3: A 1 on `evt_pulse` bit 0, 2, 3, 4, 5 or 7 at a rising edge makes that bit of `evt_rd_data` 1 from that edge on. The bit stays 1 until a read or a clear.
- R4: `summary` equals the OR over all bits of (`evt_rd_data` AND `ena_rdata`). It follows the registers with no extra cycle of delay.
- R5: A caught event whose mask bit is 0 still shows in `evt_rd_data` but does not raise `summary`.
- R6: `evt_rd_data` shows the register contents before the read edge. When `evt_rd` is 1 at a rising edge, the register is empty after that edge.
- R7: When `clr_cmd` is 1 at a rising edge, the event register is empty after that edge.
- R8: An event pulse at the same edge as a read or a clear is not lost. After that edge, the register holds exactly the pulsed bits, less bits 6 and 1.
- R9: When `ena_wr` is 1 at a rising edge, `ena_rdata` takes `ena_wdata` after that edge. Otherwise `ena_rdata` is unchanged, including across reads and clears of the event register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_pulse | input | 8 | One-cycle event pulses, one line per bit position |
| evt_rd | input | 1 | Destructive read strobe for the event register |
| evt_rd_data | output | 8 | Current event register contents |
| clr_cmd | input | 1 | Clear command for the event register |
| ena_wr | input | 1 | Enable mask write strobe |
| ena_wdata | input | 8 | Enable mask write value |
| ena_rdata | output | 8 | Current enable mask |
| summary | output | 1 | OR of enabled, caught events |

## Verification
The bench builds the block with its default parameters: eight bits, bit 7 as the power-on flag, and bits 6 and 1 tied to zero. With these defaults the stimulus can aim pulses at the tied positions and at masked positions. It can also make events coincide with a read or a clear, and enable every position at once. A second reset in the middle of the run shows that the power-on flag returns and that the mask goes back to zero.

// File: rtl/sesr_pkg.sv
package sesr_pkg;
    localparam int EVT_W = 8;
    typedef logic [EVT_W-1:0] evt_vec_t;
    // position whose flag is set by reset
    localparam evt_vec_t PWRON_MASK = 8'h80;
    // positions that never hold an event
    localparam evt_vec_t TIED_MASK  = 8'h42;
endpackage

// File: rtl/sesr_event_latch.sv
module sesr_event_latch #(
    parameter int W = 8,
    parameter logic [W-1:0] PWRON = 8'h80,
    parameter logic [W-1:0] TIED  = 8'h42
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pulse,
    input  logic         empty_req,
    output logic [W-1:0] flags
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        if (TIED[b]) begin : g_tied
            assign flags[b] = 1'b0;
        end else begin : g_live
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= PWRON[b];
                else if (empty_req)
                    q <= pulse[b];   // coincident event survives
                else if (pulse[b])
                    q <= 1'b1;
            end
            assign flags[b] = q;
        end
    end
endmodule

// File: rtl/sesr_enable_reg.sv
module sesr_enable_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask <= '0;
        else if (wr)
            mask <= wdata;
    end
endmodule

// File: rtl/sesr_summary.sv
module sesr_summary #(
    parameter int W = 8
) (
    input  logic [W-1:0] flags,
    input  logic [W-1:0] mask,
    output logic         any_enabled
);
    always_comb any_enabled = |(flags & mask);
endmodule

// File: rtl/event_status_reg.sv
module event_status_reg
    import sesr_pkg::*;
#(
    parameter int W = EVT_W,
    parameter logic [W-1:0] PWRON = PWRON_MASK,
    parameter logic [W-1:0] TIED  = TIED_MASK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_pulse,
    input  logic         evt_rd,
    output logic [W-1:0] evt_rd_data,
    input  logic         clr_cmd,
    input  logic         ena_wr,
    input  logic [W-1:0] ena_wdata,
    output logic [W-1:0] ena_rdata,
    output logic         summary
);
    logic empty_req;
    assign empty_req = evt_rd | clr_cmd;

    sesr_event_latch #(.W(W), .PWRON(PWRON), .TIED(TIED)) u_latch (
        .clk(clk), .rst_n(rst_n), .pulse(evt_pulse),
        .empty_req(empty_req), .flags(evt_rd_data)
    );

    sesr_enable_reg #(.W(W)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr(ena_wr),
        .wdata(ena_wdata), .mask(ena_rdata)
    );

    sesr_summary #(.W(W)) u_sum (
        .flags(evt_rd_data), .mask(ena_rdata), .any_enabled(summary)
    );
endmodule

// File: rtl/event_status_reg_chk.sv
module event_status_reg_chk #(
    parameter int W = 8,
    parameter logic [W-1:0] TIED = 8'h42
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] evt_pulse,
    input logic         evt_rd,
    input logic         clr_cmd,
    input logic [W-1:0] evt_rd_data,
    input logic         ena_wr,
    input logic [W-1:0] ena_wdata,
    input logic [W-1:0] ena_rdata,
    input logic         summary
);
    localparam logic [W-1:0] LIVE = ~TIED;

    assert_tied_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_rd_data & TIED) == '0);

    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_rd || clr_cmd) |=>
            ((evt_rd_data & $past(evt_rd_data)) == $past(evt_rd_data)));

    assert_catch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        |(evt_pulse & LIVE) |=>
            ((evt_rd_data & $past(evt_pulse & LIVE)) == $past(evt_pulse & LIVE)));

    assert_summary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        summary == |(evt_rd_data & ena_rdata));

    assert_empty_keeps_new_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_rd || clr_cmd) |=> (evt_rd_data == $past(evt_pulse & LIVE)));

    assert_mask_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ena_wr |=> (ena_rdata == $past(ena_wdata)));

    assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ena_wr |=> $stable(ena_rdata));
endmodule

bind event_status_reg event_status_reg_chk #(.W(W), .TIED(TIED)) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .evt_rd(evt_rd),
    .clr_cmd(clr_cmd), .evt_rd_data(evt_rd_data), .ena_wr(ena_wr),
    .ena_wdata(ena_wdata), .ena_rdata(ena_rdata), .summary(summary)
);

// File: tb/event_status_reg_tb.sv
module event_status_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt_pulse = '0;
    logic       evt_rd = 1'b0;
    logic       clr_cmd = 1'b0;
    logic       ena_wr = 1'b0;
    logic [7:0] ena_wdata = '0;
    logic [7:0] evt_rd_data, ena_rdata;
    logic       summary;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    event_status_reg u_dut (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .evt_rd(evt_rd),
        .evt_rd_data(evt_rd_data), .clr_cmd(clr_cmd), .ena_wr(ena_wr),
        .ena_wdata(ena_wdata), .ena_rdata(ena_rdata), .summary(summary)
    );

    localparam int NV = 13;
    // stimulus: pulse, rd, clr, ena_wr, ena_wdata
    localparam logic [7:0] V_PULSE [NV] = '{8'h00, 8'h42, 8'h01, 8'h00, 8'h00, 8'h18, 8'h04,
                                           8'h00, 8'h20, 8'h08, 8'h00, 8'hFF, 8'h00};
    localparam logic       V_RD    [NV] = '{0, 0, 0, 0, 1, 0, 0, 0, 0, 1, 0, 0, 1};
    localparam logic       V_CLR   [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0};
    localparam logic       V_EW    [NV] = '{1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0};
    localparam logic [7:0] V_EWD   [NV] = '{8'h25, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
                                           8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00};
    // expected after the edge: event reg, mask, summary
    localparam logic [7:0] E_EVT   [NV] = '{8'h80, 8'h80, 8'h81, 8'h81, 8'h00, 8'h18, 8'h1C,
                                           8'h00, 8'h20, 8'h08, 8'h08, 8'hBD, 8'h00};
    localparam logic [7:0] E_ENA   [NV] = '{8'h25, 8'h25, 8'h25, 8'h25, 8'h25, 8'h25, 8'h25,
                                           8'h25, 8'h25, 8'h25, 8'hFF, 8'hFF, 8'hFF};
    localparam logic       E_SUM   [NV] = '{0, 0, 1, 1, 0, 0, 1, 0, 1, 0, 1, 1, 0};

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        evt_pulse = '0; evt_rd = 0; clr_cmd = 0; ena_wr = 0; ena_wdata = '0;
    endtask

    initial begin : watchdog
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: values during reset
        repeat (3) @(posedge clk);
        #1;
        check8("R1 evt in reset", evt_rd_data, 8'h80);
        check8("R1 ena in reset", ena_rdata, 8'h00);
        check1("R1 summary in reset", summary, 1'b0);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1;
        check8("R1 evt after reset", evt_rd_data, 8'h80);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            evt_pulse = V_PULSE[i]; evt_rd = V_RD[i]; clr_cmd = V_CLR[i];
            ena_wr = V_EW[i]; ena_wdata = V_EWD[i];
            if (i == 4) check8("R6 data before read edge", evt_rd_data, 8'h81);
            @(posedge clk); #1;
            // covers R2 R3 R4 R5 R6 R7 R8 R9 by step
            check8($sformatf("R2/R3/R5-R8 evt step %0d", i), evt_rd_data, E_EVT[i]);
            check8($sformatf("R9 ena step %0d", i), ena_rdata, E_ENA[i]);
            check1($sformatf("R4 summary step %0d", i), summary, E_SUM[i]);
            idle_inputs();
        end

        // R9: mask readback with no write, after reads and clears
        @(negedge clk); clr_cmd = 1; evt_rd = 1;
        @(posedge clk); #1; idle_inputs();
        check8("R9 ena kept after clear+read", ena_rdata, 8'hFF);
        check8("R7 clear empties", evt_rd_data, 8'h00);

        // R2: pulses only on tied bits with full mask
        @(negedge clk); evt_pulse = 8'h42;
        @(posedge clk); #1; idle_inputs();
        check8("R2 tied bits stay 0", evt_rd_data, 8'h00);
        check1("R2 no summary from tied bits", summary, 1'b0);

        // R1: second reset restores power-on flag and mask
        @(negedge clk); evt_pulse = 8'h01;
        @(posedge clk); #1; idle_inputs();
        @(negedge clk); rst_n = 0;
        #1;
        check8("R1 evt on reset", evt_rd_data, 8'h80);
        check8("R1 ena on reset", ena_rdata, 8'h00);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1;
        check1("R1 summary after reset", summary, 1'b0);

        // R6: read the power-on flag out, then R4 with bit 7 enabled
        @(negedge clk); ena_wr = 1; ena_wdata = 8'h80;
        @(posedge clk); #1; idle_inputs();
        check1("R4 power-on enabled", summary, 1'b1);
        @(negedge clk); evt_rd = 1;
        @(posedge clk); #1; idle_inputs();
        check8("R6 read clears power-on", evt_rd_data, 8'h00);
        check1("R4 summary drops after read", summary, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule